// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable ROM

This block models a 2048-word by 8-bit programmable read-only memory whose cells behave like fuses. Every cell starts at 0 and can be set to 1 by programming. Once set, it stays at 1 until the next reset. The address enters through an on-chip latch. The latch captures the address bus in the clock cycle where the active-low chip enable is first seen low, and holds it for as long as the chip enable stays low. While the chip enable is high, address changes have no effect.

All strobes are sampled on a system clock, and an edge-detect register finds the chip-enable falling edge, so the whole block is synthesizable. The storage is a 128-row by 128-column matrix. A gated row decoder and a gated column decoder take the row and an 8-bit column group from the latched address. A registered output stage drives the data bus. It also drives a per-bit drive enable, which a pad ring or a bus mux uses as the three-state control. Programming uses the same latched address. It ORs the program data into the stored word.

Top module: `otp_latched_rom`

## Requirements
- R1: After reset, every word reads as 0x00, `drive_en_o` is 0x00 and `data_o` is 0x00.
- R2: The address is captured at the first rising clock edge where `ce_n_i` is sampled low after having been sampled high. While `ce_n_i` stays low, later changes of `addr_i` do not change which word is read.
- R3: At a rising edge where `ce_n_i`=0, `oe_n_i`=0 and `prog_en_i`=0 are sampled, the word at the latched address is registered. After that edge, `drive_en_o` is 0xFF and `data_o` carries the word. Before that edge, the output is not yet driven.
- R4: After an edge where `ce_n_i`=1, `oe_n_i`=1 or `prog_en_i`=1 was sampled, `drive_en_o` is 0x00 and `data_o` is 0x00.
- R5: At an edge where `ce_n_i`=0 and `prog_en_i`=1 are sampled, the word at the latched address becomes its old value OR `prog_data_i`.
- R6: A cycle with `prog_en_i`=0, or with `ce_n_i`=1, changes no stored bit, whatever `prog_data_i` holds.
- R7: Programming never clears a bit. A 0 in `prog_data_i` leaves the stored bit as it was.
- R8: Address bits [10:4] select the row and bits [3:0] select the 8-bit column group. Each of the 2048 addresses reads its own word, exactly as a flat 2048x8 table would, and writing one address leaves its neighbours unchanged.
- R9: All bits of `drive_en_o` are always equal: either 0x00 or 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears every cell and the output stage |
| addr_i | input | 11 | Word address, captured by the chip-enable falling edge |
| ce_n_i | input | 1 | Active-low chip enable; its falling edge latches the address |
| oe_n_i | input | 1 | Active-low output enable; gates the read onto the bus |
| prog_en_i | input | 1 | Program enable; high selects programming, low for normal reads |
| prog_data_i | input | 8 | Bits to set at the latched word while programming |
| data_o | output | 8 | Read data; 0x00 whenever not driven |
| drive_en_o | output | 8 | Per-bit three-state drive enable for `data_o` |

## Verification
Each result is due a fixed number of clock edges after its stimulus. A read appears after the single edge that samples both strobes low. A program takes effect at the edge that samples it and is seen on the next read. The address latch moves only at the edge that detects the chip-enable fall. The bench drives inputs on the falling clock edge. It checks outputs at the next falling edge, half a cycle after the rising edge that should have produced them. For the latency check, it also looks at the bus just after driving the strobes, to confirm nothing is driven before that rising edge. Checks that something is ignored are followed by a full read through the normal port, so any stray write would show up.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

   // Which end of the address feeds the row decoder
   typedef enum logic {
      MAP_ROW_HIGH = 1'b0,
      MAP_ROW_LOW  = 1'b1
   } addr_map_e;

   // Width of an index able to address n items (at least 1)
   function automatic int unsigned idx_w(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/otp_strobe_ctl.sv
// Samples the strobes, detects the chip-enable fall and keeps the address latch.
module otp_strobe_ctl #(
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              prog_en_i,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] addr_lat,
   output logic              rd_go,
   output logic              wr_go
);

   logic ce_n_q;
   logic ce_fall;

   // previous sampled chip enable; resets inactive so a low CE latches at once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_n_q <= 1'b1;
      else        ce_n_q <= ce_n_i;
   end

   assign ce_fall = ce_n_q & ~ce_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_lat <= '0;
      else if (ce_fall) addr_lat <= addr_i;
   end

   // in the capture cycle the fresh address is used directly
   assign eff_addr = ce_fall ? addr_i : addr_lat;

   assign rd_go = ~ce_n_i & ~oe_n_i & ~prog_en_i;
   assign wr_go = ~ce_n_i & prog_en_i;

endmodule

// File: rtl/otp_gated_decode.sv
// Gated row and column-group decoders; both one-hot outputs are all zero when idle.
module otp_gated_decode #(
   parameter int unsigned           ROW_BITS = 7,
   parameter int unsigned           COL_BITS = 4,
   parameter otp_rom_pkg::addr_map_e MAP     = otp_rom_pkg::MAP_ROW_HIGH,
   localparam int unsigned          ADDR_W   = ROW_BITS + COL_BITS,
   localparam int unsigned          ROWS     = 1 << ROW_BITS,
   localparam int unsigned          GROUPS   = 1 << COL_BITS
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              gate,
   output logic [ROWS-1:0]   row_hot,
   output logic [GROUPS-1:0] col_hot
);

   logic [ROW_BITS-1:0] row_idx;
   logic [COL_BITS-1:0] col_idx;

   generate
      if (MAP == otp_rom_pkg::MAP_ROW_HIGH) begin : g_row_high
         assign row_idx = addr[ADDR_W-1 -: ROW_BITS];
         assign col_idx = addr[COL_BITS-1:0];
      end else begin : g_row_low
         assign row_idx = addr[ROW_BITS-1:0];
         assign col_idx = addr[ADDR_W-1 -: COL_BITS];
      end
   endgenerate

   always_comb begin
      row_hot          = '0;
      row_hot[row_idx] = gate;
   end

   always_comb begin
      col_hot          = '0;
      col_hot[col_idx] = gate;
   end

endmodule

// File: rtl/otp_fuse_array.sv
// Row-organised cell matrix. Writes only OR bits in; reset clears everything.
module otp_fuse_array #(
   parameter int unsigned ROWS   = 128,
   parameter int unsigned GROUPS = 16,
   parameter int unsigned WORD_W = 8,
   localparam int unsigned ROW_W = GROUPS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROWS-1:0]   row_hot,
   input  logic [GROUPS-1:0] col_hot,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_word
);

   logic [ROW_W-1:0] set_mask;
   logic [ROW_W-1:0] row_vec [ROWS];
   logic [ROW_W-1:0] sel_row;

   // spread the program data into the selected column group only
   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_mask
         assign set_mask[g*WORD_W +: WORD_W] = col_hot[g] ? wr_data : '0;
      end
   endgenerate

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic [ROW_W-1:0] cells;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cells <= '0;
            else if (wr_en && row_hot[r]) cells <= cells | set_mask;
         end
         assign row_vec[r] = cells;
      end
   endgenerate

   // gated row select: AND-OR over the one-hot row lines
   always_comb begin
      sel_row = '0;
      for (int r = 0; r < ROWS; r++) begin
         sel_row |= row_vec[r] & {ROW_W{row_hot[r]}};
      end
   end

   // gated column select
   always_comb begin
      rd_word = '0;
      for (int g = 0; g < GROUPS; g++) begin
         rd_word |= sel_row[g*WORD_W +: WORD_W] & {WORD_W{col_hot[g]}};
      end
   end

endmodule

// File: rtl/otp_out_stage.sv
// Registered read data and per-bit three-state enables.
module otp_out_stage #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic [WORD_W-1:0] rd_word,
   output logic [WORD_W-1:0] data_o,
   output logic [WORD_W-1:0] drive_en_o
);

   logic drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drive_q <= 1'b0;
      else        drive_q <= rd_go;
   end

   generate
      for (genvar b = 0; b < WORD_W; b++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= rd_go & rd_word[b];
         end
         assign data_o[b]     = bit_q;
         assign drive_en_o[b] = drive_q;
      end
   endgenerate

endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom #(
   parameter int unsigned            WORD_W   = 8,
   parameter int unsigned            ROW_BITS = 7,
   parameter int unsigned            COL_BITS = 4,
   parameter otp_rom_pkg::addr_map_e MAP      = otp_rom_pkg::MAP_ROW_HIGH,
   localparam int unsigned           ADDR_W   = ROW_BITS + COL_BITS,
   localparam int unsigned           ROWS     = 1 << ROW_BITS,
   localparam int unsigned           GROUPS   = 1 << COL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              prog_en_i,
   input  logic [WORD_W-1:0] prog_data_i,
   output logic [WORD_W-1:0] data_o,
   output logic [WORD_W-1:0] drive_en_o
);

   generate
      if (WORD_W < 1) begin : g_bad_word
         $error("otp_latched_rom: WORD_W must be at least 1");
      end
      if (ROW_BITS < 1 || ROW_BITS > 10) begin : g_bad_rows
         $error("otp_latched_rom: ROW_BITS out of range 1..10");
      end
      if (COL_BITS < 1 || COL_BITS > 8) begin : g_bad_cols
         $error("otp_latched_rom: COL_BITS out of range 1..8");
      end
      if (otp_rom_pkg::idx_w(ROWS) != ROW_BITS) begin : g_bad_idx
         $error("otp_latched_rom: row index width mismatch");
      end
   endgenerate

   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] addr_lat;
   logic              rd_go;
   logic              wr_go;
   logic [ROWS-1:0]   row_hot;
   logic [GROUPS-1:0] col_hot;
   logic [WORD_W-1:0] rd_word;

   otp_strobe_ctl #(.ADDR_W(ADDR_W)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr_i),
      .ce_n_i    (ce_n_i),
      .oe_n_i    (oe_n_i),
      .prog_en_i (prog_en_i),
      .eff_addr  (eff_addr),
      .addr_lat  (addr_lat),
      .rd_go     (rd_go),
      .wr_go     (wr_go)
   );

   otp_gated_decode #(
      .ROW_BITS (ROW_BITS),
      .COL_BITS (COL_BITS),
      .MAP      (MAP)
   ) u_decode (
      .addr    (eff_addr),
      .gate    (rd_go | wr_go),
      .row_hot (row_hot),
      .col_hot (col_hot)
   );

   otp_fuse_array #(
      .ROWS   (ROWS),
      .GROUPS (GROUPS),
      .WORD_W (WORD_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_hot (row_hot),
      .col_hot (col_hot),
      .wr_en   (wr_go),
      .wr_data (prog_data_i),
      .rd_word (rd_word)
   );

   otp_out_stage #(.WORD_W(WORD_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_go      (rd_go),
      .rd_word    (rd_word),
      .data_o     (data_o),
      .drive_en_o (drive_en_o)
   );

endmodule

// File: rtl/otp_rom_chk.sv
module otp_rom_chk #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n_i,
   input logic              oe_n_i,
   input logic              prog_en_i,
   input logic [WORD_W-1:0] data_o,
   input logic [WORD_W-1:0] drive_en_o,
   input logic [ADDR_W-1:0] addr_lat,
   input logic              ce_n_q
);

   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n_i && !oe_n_i && !prog_en_i) |=> (drive_en_o == '1)); // R3

   AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n_i || oe_n_i || prog_en_i) |=> (drive_en_o == '0)); // R4

   AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en_o == '0) |-> (data_o == '0)); // R4

   AST_ENABLE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en_o == '0) || (drive_en_o == '1)); // R9

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ce_n_q && !ce_n_i) |=> $stable(addr_lat)); // R2

   AST_NO_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((drive_en_o != '0) && $past(drive_en_o != '0) && $stable(addr_lat))
      |-> (($past(data_o) & ~data_o) == '0)); // R7

endmodule

bind otp_latched_rom otp_rom_chk #(
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n_i     (ce_n_i),
   .oe_n_i     (oe_n_i),
   .prog_en_i  (prog_en_i),
   .data_o     (data_o),
   .drive_en_o (drive_en_o),
   .addr_lat   (addr_lat),
   .ce_n_q     (u_strobe.ce_n_q)
);

// File: tb/tb_otp_latched_rom.sv
module tb_otp_latched_rom;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int WORDS = 1 << AW;

   typedef struct packed {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [DW-1:0] e;
   } vec_t;

   // address, program data, expected word after the program
   localparam vec_t VEC [12] = '{
      '{11'h000, 8'h0F, 8'h0F},
      '{11'h000, 8'hF0, 8'hFF},
      '{11'h7FF, 8'hA5, 8'hA5},
      '{11'h7FF, 8'h00, 8'hA5},
      '{11'h7FF, 8'h5A, 8'hFF},
      '{11'h010, 8'h81, 8'h81},
      '{11'h00F, 8'h3C, 8'h3C},
      '{11'h001, 8'h42, 8'h42},
      '{11'h400, 8'h18, 8'h18},
      '{11'h010, 8'h02, 8'h83},
      '{11'h3A7, 8'hC3, 8'hC3},
      '{11'h3A7, 8'h3C, 8'hFF}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          ce_n_i = 1'b1;
   logic          oe_n_i = 1'b1;
   logic          prog_en_i = 1'b0;
   logic [DW-1:0] prog_data_i = '0;
   logic [DW-1:0] data_o;
   logic [DW-1:0] drive_en_o;

   logic [DW-1:0] mdl [WORDS];
   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_latched_rom dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (addr_i),
      .ce_n_i      (ce_n_i),
      .oe_n_i      (oe_n_i),
      .prog_en_i   (prog_en_i),
      .prog_data_i (prog_data_i),
      .data_o      (data_o),
      .drive_en_o  (drive_en_o)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      ce_n_i = 1'b1; oe_n_i = 1'b1; prog_en_i = 1'b0; prog_data_i = '0;
   endtask

   task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
      idle();
      @(negedge clk);
      addr_i = a; ce_n_i = 1'b0; prog_en_i = 1'b1; prog_data_i = d;
      @(negedge clk);
      ce_n_i = 1'b1; prog_en_i = 1'b0; prog_data_i = '0;
      mdl[a] = mdl[a] | d;
   endtask

   // returns the word read; leaves strobes low
   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] q, output logic [DW-1:0] en);
      idle();
      @(negedge clk);
      addr_i = a; ce_n_i = 1'b0; oe_n_i = 1'b0;
      @(negedge clk);
      q = data_o; en = drive_en_o;
   endtask

   task automatic clear_model();
      for (int i = 0; i < WORDS; i++) mdl[i] = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] q, en, old;
      logic [AW-1:0] ra;
      clear_model();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 drive_en after reset", drive_en_o, 8'h00);
      check("R1 data after reset", data_o, 8'h00);
      rd(11'h7FF, q, en);
      check("R1 word after reset", q, 8'h00);

      // R3: latency and enables
      idle();
      @(negedge clk);
      addr_i = 11'h000; ce_n_i = 1'b0; oe_n_i = 1'b0;
      #1 check("R3 not driven before edge", drive_en_o, 8'h00);
      @(negedge clk);
      check("R3 driven after edge", drive_en_o, 8'hFF);
      check("R9 uniform enable", drive_en_o, 8'hFF);

      // R5 R7 R8: vector table
      foreach (VEC[i]) begin
         prog(VEC[i].a, VEC[i].d);
         rd(VEC[i].a, q, en);
         check("R5 R7 table word", q, VEC[i].e);
         check("R3 table enable", en, 8'hFF);
      end

      // R8: neighbours untouched
      rd(11'h002, q, en); check("R8 neighbour 002", q, 8'h00);
      rd(11'h011, q, en); check("R8 neighbour 011", q, 8'h00);
      rd(11'h7FE, q, en); check("R8 neighbour 7FE", q, 8'h00);
      rd(11'h00E, q, en); check("R8 neighbour 00E", q, 8'h00);

      // R4: each idle condition releases the bus
      idle(); @(negedge clk);
      addr_i = 11'h000; ce_n_i = 1'b1; oe_n_i = 1'b0;
      @(negedge clk); check("R4 ce high", drive_en_o, 8'h00); check("R4 ce high data", data_o, 8'h00);
      ce_n_i = 1'b0; oe_n_i = 1'b1;
      @(negedge clk); check("R4 oe high", drive_en_o, 8'h00);
      addr_i = 11'h556; oe_n_i = 1'b0; prog_en_i = 1'b1; prog_data_i = 8'h00;
      @(negedge clk); check("R4 prog high", drive_en_o, 8'h00);

      // R6: writes refused without prog enable or with chip enable high
      idle(); @(negedge clk);
      addr_i = 11'h555; ce_n_i = 1'b0; oe_n_i = 1'b1; prog_data_i = 8'hFF;
      repeat (2) @(negedge clk);
      idle(); @(negedge clk);
      addr_i = 11'h555; prog_en_i = 1'b1; prog_data_i = 8'hFF;
      repeat (2) @(negedge clk);
      rd(11'h555, q, en);
      check("R6 no stray write", q, 8'h00);

      // R2: address held while CE low
      prog(11'h123, 8'h11);
      prog(11'h124, 8'h22);
      rd(11'h123, q, en);
      check("R2 first word", q, 8'h11);
      addr_i = 11'h124;
      @(negedge clk);
      check("R2 address ignored while CE low", data_o, 8'h11);
      @(negedge clk);
      check("R2 still held", data_o, 8'h11);
      ce_n_i = 1'b1;
      @(negedge clk);
      addr_i = 11'h123;
      @(negedge clk);
      ce_n_i = 1'b0; addr_i = 11'h124;
      @(negedge clk);
      check("R2 new fall latches new address", data_o, 8'h22);

      // random programming
      for (int i = 0; i < 40; i++) begin
         prog(AW'($urandom % WORDS), DW'($urandom % 256));
      end

      // R7: reprogram with the complement; earlier bits must survive
      ra = 11'h3A7 ^ 11'h001;
      prog(ra, 8'h96);
      old = mdl[ra];
      prog(ra, ~old);
      rd(ra, q, en);
      check("R7 old bits kept", q & old, old);
      check("R7 result", q, 8'hFF);

      // R8: full sweep against the flat model
      for (int a = 0; a < WORDS; a++) begin
         rd(AW'(a), q, en);
         check("R8 sweep", q, mdl[a]);
      end

      // R1: reset mid-run clears fuses
      idle();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      clear_model();
      @(negedge clk);
      check("R1 enable after second reset", drive_en_o, 8'h00);
      rd(11'h7FF, q, en); check("R1 cleared 7FF", q, 8'h00);
      rd(11'h000, q, en); check("R1 cleared 000", q, 8'h00);

      idle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule